// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Retry Controller

This block sits in the transmit path of a half-duplex Ethernet MAC and sequences the transmission attempts of one frame. Each attempt begins with a start pulse at the first preamble bit. From that point the block counts bit-time strobes. A collision seen before the slot window of `SLOT_BITS` bit times has elapsed is treated as early, and the frame is retried. The block first pulses a FIFO rewind and then asks the backoff logic for the next attempt. A collision after the window abandons the frame as a late collision. If an early collision hits on the last permitted attempt, the frame is dropped with a retry-exhausted status.

The same window sets how much of the buffered frame may be discarded. The release count stays at zero until the window has passed without a collision. After that it follows the number of bytes sent, so the FIFO never gives up data that a retry might still need. When full-duplex or disable-retry mode is set at the start of an attempt, collision handling is bypassed and every byte may be released as soon as it has been sent. Each frame ends with a one-cycle status report: success, retry-exhausted or late collision.

Top module: `txcr_retry_ctrl`

## Requirements
- R1: After synchronous reset, `rewind_o`, `retry_req_o`, `attempt_o`, `release_cnt_o` and all status outputs are zero, and the block is idle.
- R2: A collision (`col_i` high in a cycle while sending, not bypassed) after fewer than `SLOT_BITS` bit strobes since the attempt start is early. `rewind_o` is high for exactly the next cycle.
- R3: `retry_req_o` pulses for one cycle, in the cycle after `rewind_o`. The next `start_i` then begins a new attempt, and `attempt_o` rises by one.
- R4: `attempt_o` never exceeds `MAX_ATTEMPTS` (16). An early collision on attempt 16 gives no rewind. Instead it gives a status pulse with `stat_retry_err_o` set, and the block goes idle.
- R5: A collision once `SLOT_BITS` (512) or more bit strobes have passed in the attempt gives a status pulse with `stat_late_col_o` set, with no rewind and no retry request.
- R6: `frame_end_i` while sending with no collision gives a status pulse with `stat_ok_o` set. In every status pulse exactly one of the three flags is set, and the pulse comes one cycle after the ending event.
- R7: With collision handling active, `release_cnt_o` is zero until `SLOT_BITS` strobes have passed. After that it equals the bytes sent in the current attempt, and it returns to zero at each attempt start.
- R8: If `full_duplex_i` or `no_retry_i` is high when an attempt starts, collisions are ignored for that attempt. `release_cnt_o` then follows the bytes sent from the first byte.
- R9: `start_i` while idle begins a new frame with `attempt_o` = 1, whatever the previous frame did.
- R10: While idle, `col_i`, `byte_sent_i` and `frame_end_i` have no effect: no pulse, and `release_cnt_o` is unchanged. `start_i` while sending or rewinding is ignored.
- R11: The bit counter saturates once the window is reached. A collision after thousands of bit times is still reported as late.
- R12: A collision and `frame_end_i` in the same cycle count as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One pulse per transmitted bit time |
| start_i | input | 1 | First preamble bit of an attempt |
| byte_sent_i | input | 1 | One byte of the attempt has been sent |
| frame_end_i | input | 1 | Last bit of the attempt has been sent |
| col_i | input | 1 | Collision detected |
| full_duplex_i | input | 1 | Full-duplex mode, bypasses collision handling |
| no_retry_i | input | 1 | Disable-retry mode, bypasses collision handling |
| rewind_o | output | 1 | Reset the FIFO read pointer to the frame start |
| retry_req_o | output | 1 | Request the next attempt from the backoff logic |
| attempt_o | output | ATT_W | Number of the current attempt, 1 to MAX_ATTEMPTS |
| release_cnt_o | output | BYTE_W | Bytes of the attempt the FIFO may discard |
| stat_valid_o | output | 1 | Frame status pulse |
| stat_ok_o | output | 1 | Frame sent |
| stat_retry_err_o | output | 1 | Attempt limit exhausted |
| stat_late_col_o | output | 1 | Late collision, frame abandoned |

## Verification
The bench builds the block with its default parameters: a 512-bit slot window, 16 attempts and 12-bit byte counts. Both limits can be reached within a few thousand cycles. The bench therefore drives collisions at 511 and at 512 strobes, a full run of 16 early collisions, and a collision thousands of bit times into a frame. It also runs random multi-attempt frames with bypass modes mixed in.

// File: rtl/txcr_pkg.sv
package txcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_REWIND = 2'd2,
    ST_WAIT   = 2'd3
  } txcr_state_e;
endpackage

// File: rtl/txcr_slot_timer.sv
module txcr_slot_timer #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic past_o
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SLOT_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (run_i && tick_i && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign past_o = (cnt == LIMIT);

  AST_SLOT_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT); // R11

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_o && !clear_i) |=> past_o); // R11
endmodule

// File: rtl/txcr_release_track.sv
module txcr_release_track #(
  parameter int BYTE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              byte_i,
  input  logic              open_i,
  output logic [BYTE_W-1:0] rel_o
);
  logic [BYTE_W-1:0] cnt;
  logic [BYTE_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clear_i) begin
      cnt_n = '0;
    end else if (run_i && byte_i && cnt != {BYTE_W{1'b1}}) begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rel_o <= '0;
    end else begin
      cnt <= cnt_n;
      if (clear_i) begin
        rel_o <= '0;
      end else if (open_i) begin
        rel_o <= cnt_n;
      end
    end
  end

  AST_REL_MONO: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && open_i) |=> rel_o >= $past(rel_o)); // R7
endmodule

// File: rtl/txcr_attempt_fsm.sv
module txcr_attempt_fsm
  import txcr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             frame_end_i,
  input  logic             col_i,
  input  logic             bypass_i,
  input  logic             past_i,
  output logic             accept_o,
  output logic             sending_o,
  output logic             bypass_o,
  output logic             rewind_o,
  output logic             retry_req_o,
  output logic [ATT_W-1:0] attempt_o,
  output logic             stat_valid_o,
  output logic             stat_ok_o,
  output logic             stat_retry_err_o,
  output logic             stat_late_col_o
);
  localparam logic [ATT_W-1:0] LAST = ATT_W'(MAX_ATTEMPTS);

  txcr_state_e state;

  assign accept_o  = start_i && (state == ST_IDLE || state == ST_WAIT);
  assign sending_o = (state == ST_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= ST_IDLE;
      bypass_o         <= 1'b0;
      rewind_o         <= 1'b0;
      retry_req_o      <= 1'b0;
      attempt_o        <= '0;
      stat_valid_o     <= 1'b0;
      stat_ok_o        <= 1'b0;
      stat_retry_err_o <= 1'b0;
      stat_late_col_o  <= 1'b0;
    end else begin
      rewind_o         <= 1'b0;
      retry_req_o      <= 1'b0;
      stat_valid_o     <= 1'b0;
      stat_ok_o        <= 1'b0;
      stat_retry_err_o <= 1'b0;
      stat_late_col_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state     <= ST_SEND;
            attempt_o <= ATT_W'(1);
            bypass_o  <= bypass_i;
          end
        end
        ST_WAIT: begin
          if (start_i) begin
            state     <= ST_SEND;
            attempt_o <= attempt_o + 1'b1;
            bypass_o  <= bypass_i;
          end
        end
        ST_SEND: begin
          if (col_i && !bypass_o) begin
            if (past_i) begin
              state           <= ST_IDLE;
              stat_valid_o    <= 1'b1;
              stat_late_col_o <= 1'b1;
            end else if (attempt_o == LAST) begin
              state            <= ST_IDLE;
              stat_valid_o     <= 1'b1;
              stat_retry_err_o <= 1'b1;
            end else begin
              state    <= ST_REWIND;
              rewind_o <= 1'b1;
            end
          end else if (frame_end_i) begin
            state        <= ST_IDLE;
            stat_valid_o <= 1'b1;
            stat_ok_o    <= 1'b1;
          end
        end
        ST_REWIND: begin
          state       <= ST_WAIT;
          retry_req_o <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REWIND_SEQ: assert property (@(posedge clk) disable iff (rst)
    rewind_o |=> retry_req_o); // R3

  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (rst)
    attempt_o <= LAST); // R4

  AST_ATT_STEP: assert property (@(posedge clk) disable iff (rst)
    (attempt_o != $past(attempt_o)) |->
      (attempt_o == $past(attempt_o) + 1'b1 || attempt_o == ATT_W'(1))); // R9

  AST_STAT_ONE: assert property (@(posedge clk) disable iff (rst)
    $countones({stat_ok_o, stat_retry_err_o, stat_late_col_o}) == (stat_valid_o ? 1 : 0)); // R6

  AST_NO_REWIND_ON_STAT: assert property (@(posedge clk) disable iff (rst)
    stat_valid_o |-> !rewind_o); // R5
endmodule

// File: rtl/txcr_retry_ctrl.sv
module txcr_retry_ctrl #(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BYTE_W       = 12,
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick_i,
  input  logic              start_i,
  input  logic              byte_sent_i,
  input  logic              frame_end_i,
  input  logic              col_i,
  input  logic              full_duplex_i,
  input  logic              no_retry_i,
  output logic              rewind_o,
  output logic              retry_req_o,
  output logic [ATT_W-1:0]  attempt_o,
  output logic [BYTE_W-1:0] release_cnt_o,
  output logic              stat_valid_o,
  output logic              stat_ok_o,
  output logic              stat_retry_err_o,
  output logic              stat_late_col_o
);
  logic accept;
  logic sending;
  logic bypass_q;
  logic past_slot;

  txcr_attempt_fsm #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_fsm (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .frame_end_i      (frame_end_i),
    .col_i            (col_i),
    .bypass_i         (full_duplex_i | no_retry_i),
    .past_i           (past_slot),
    .accept_o         (accept),
    .sending_o        (sending),
    .bypass_o         (bypass_q),
    .rewind_o         (rewind_o),
    .retry_req_o      (retry_req_o),
    .attempt_o        (attempt_o),
    .stat_valid_o     (stat_valid_o),
    .stat_ok_o        (stat_ok_o),
    .stat_retry_err_o (stat_retry_err_o),
    .stat_late_col_o  (stat_late_col_o)
  );

  txcr_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .run_i   (sending),
    .tick_i  (bit_tick_i),
    .past_o  (past_slot)
  );

  txcr_release_track #(.BYTE_W(BYTE_W)) u_release (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .run_i   (sending),
    .byte_i  (byte_sent_i),
    .open_i  (past_slot | bypass_q),
    .rel_o   (release_cnt_o)
  );

  AST_REL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (release_cnt_o != '0) |-> (past_slot || bypass_q)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sending && !accept) |=> (release_cnt_o == $past(release_cnt_o))); // R10
endmodule

// File: tb/txcr_retry_ctrl_test.sv
module txcr_retry_ctrl_test;
  localparam int SLOT = 512;
  localparam int MAXA = 16;
  localparam int BW   = 12;
  localparam int AW   = $clog2(MAXA + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, start = 0, bsent = 0, fend = 0, col = 0, fdx = 0, nret = 0;
  logic rewind, rreq, sv, sok, srt, slt;
  logic [AW-1:0] att;
  logic [BW-1:0] rel;

  int errs = 0;
  int checks = 0;
  int n_pulse = 0;

  always #2 clk = ~clk;

  txcr_retry_ctrl uut (
    .clk(clk), .rst(rst), .bit_tick_i(tick), .start_i(start), .byte_sent_i(bsent),
    .frame_end_i(fend), .col_i(col), .full_duplex_i(fdx), .no_retry_i(nret),
    .rewind_o(rewind), .retry_req_o(rreq), .attempt_o(att), .release_cnt_o(rel),
    .stat_valid_o(sv), .stat_ok_o(sok), .stat_retry_err_o(srt), .stat_late_col_o(slt)
  );

  always @(negedge clk) if (!rst) n_pulse += int'(rewind) + int'(rreq) + int'(sv);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit b, input bit e, input bit c, input bit s);
    tick = t; bsent = b; fend = e; col = c; start = s;
    @(negedge clk);
    tick = 0; bsent = 0; fend = 0; col = 0; start = 0;
  endtask

  function automatic int exp_rel(input int n, input bit byp);
    return (byp || n >= SLOT) ? n / 8 : 0;
  endfunction

  // kind: 0 clean end, 1 collision, 2 collision together with frame end
  // result: 0 ok, 1 retry, 2 retry exhausted, 3 late
  task automatic attempt(input int n, input int kind, input bit byp, input int a, output int res);
    step(0, 0, 0, 0, 1);
    chk("R3/R9 attempt number", int'(att), a);
    for (int i = 0; i < n; i++) step(1, (i % 8) == 7, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R7/R8 release count", int'(rel), exp_rel(n, byp));
    if (kind == 0 || byp) res = 0;
    else if (n >= SLOT) res = 3;
    else if (a == MAXA) res = 2;
    else res = 1;
    if (kind == 0) step(0, 0, 1, 0, 0);
    else if (kind == 1) step(0, 0, 0, 1, 0);
    else step(0, 0, 1, 1, 0);
    if (kind == 1 && byp) begin
      chk("R8 collision ignored", int'(rewind) + int'(sv), 0);
      step(0, 0, 1, 0, 0);
    end
    chk("R2 rewind pulse", int'(rewind), int'(res == 1));
    chk("R6 status valid", int'(sv), int'(res != 1));
    chk("R6 ok flag", int'(sok), int'(res == 0));
    chk("R4 retry error flag", int'(srt), int'(res == 2));
    chk("R5 late flag", int'(slt), int'(res == 3));
    step(0, 0, 0, 0, 0);
    chk("R3 retry request", int'(rreq), int'(res == 1));
    chk("R3 rewind one cycle", int'(rewind), 0);
  endtask

  task automatic rand_frame();
    int a = 1;
    int res = 1;
    bit byp = ($urandom_range(0, 3) == 0);
    fdx = byp & $urandom_range(0, 1);
    nret = byp & !fdx;
    while (res == 1) begin
      int k = $urandom_range(0, 99);
      int n;
      int kind;
      if (k < 55) begin kind = 1; n = ($urandom_range(0, 4) == 0) ? $urandom_range(500, 511) : $urandom_range(0, 120); end
      else if (k < 70) begin kind = 1; n = $urandom_range(512, 540); end
      else begin kind = 0; n = $urandom_range(0, 600); end
      attempt(n, kind, byp, a, res);
      a++;
    end
    fdx = 0; nret = 0;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int res;
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", int'(rewind) + int'(rreq) + int'(sv) + int'(sok) + int'(srt) + int'(slt), 0);
    chk("R1 reset attempt", int'(att), 0);
    chk("R1 reset release", int'(rel), 0);
    rst = 0;
    step(0, 0, 0, 0, 0);
    // R2 / R5 window edge
    attempt(511, 1, 0, 1, res);
    chk("R2 early at 511", res, 1);
    attempt(512, 1, 0, 2, res);
    chk("R5 late at 512", res, 3);
    // R10 idle inputs have no effect
    base = n_pulse;
    step(1, 1, 0, 0, 0); step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 0, 0);
    chk("R10 idle pulses", n_pulse - base, 0);
    chk("R10 idle release", int'(rel), 64);
    // R9 new frame restarts count; R4 limit of 16
    for (int a = 1; a <= MAXA; a++) begin
      attempt(5 + a, 1, 0, a, res);
      chk("R4 sequence result", res, (a == MAXA) ? 2 : 1);
    end
    // R12 collision with frame end counts as collision
    attempt(30, 2, 0, 1, res);
    chk("R12 simultaneous", res, 1);
    // R10 start while sending ignored
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    chk("R10 start in send ignored", int'(att), 2);
    step(0, 0, 1, 0, 0);
    chk("R6 ok after ignored start", int'(sok), 1);
    step(0, 0, 0, 0, 0);
    // R11 saturation
    attempt(3000, 1, 0, 1, res);
    chk("R11 late after long run", res, 3);
    // R8 bypass modes
    nret = 1;
    attempt(40, 1, 1, 1, res);
    chk("R8 no-retry bypass", res, 0);
    nret = 0; fdx = 1;
    attempt(100, 1, 1, 1, res);
    chk("R8 full-duplex bypass", res, 0);
    fdx = 0;
    // random frames
    for (int f = 0; f < 40; f++) rand_frame();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule